// File: doc/BRIEF.md
# Page Write Buffer with Stop-Qualified Commit

This block sits between the serial protocol engine of a byte-addressed non-volatile memory and its array write port. When a write transfer has received its address, the protocol engine pulses `xfer_start` with the full address. Each data byte that follows is captured into a page latch at the current in-page offset, and a per-byte valid bit is set. The offset advances after each byte and wraps inside the page. A byte that lands on an offset already filled in the same transfer replaces the earlier byte.

The latched bytes go to the array only when the transfer ends with a stop that the engine marks as falling in the slot right after a data-byte acknowledge (`stop_slot_ok`). Such a stop raises `busy` for a fixed number of clock cycles. While busy, the block walks the page offsets in ascending order and drives one array write for each offset that holds a valid byte. Offsets without a valid byte are not written, so they keep their previous contents (FFh in an erased array). When busy drops, `next_addr` points one past the last latched byte. A stop in any other slot, or a stop with no data bytes, discards the buffer and starts no write cycle.

Top module: `pgwr_buffer`

## Requirements
- R1: After reset, `busy` is 0, `mem_we` is 0 and `next_addr` is 0.
- R2: A `xfer_start` pulse (while not busy) loads `next_addr` with `addr_in` on the next clock. It also clears every valid bit and sets the in-page offset to the low log2(PAGE_BYTES) bits of `addr_in`.
- R3: Each `byte_stb` in an open transfer latches `byte_in` at the current offset, sets that offset's valid bit, and advances the offset modulo PAGE_BYTES. A later byte at an offset already used replaces the earlier byte.
- R4: A `stop_pulse` with `stop_slot_ok`=1, in an open transfer that holds at least one byte, raises `busy` on the next clock. `busy` then stays high for exactly max(WRITE_CYCLES, PAGE_BYTES) cycles.
- R5: While busy, `mem_we` pulses once for each valid offset, in ascending offset order. Each write carries `mem_addr` = {page bits of the start address, offset} and the last byte latched at that offset. Offsets without a valid bit are never written, so erased locations keep FFh.
- R6: A `stop_pulse` with `stop_slot_ok`=0 starts no write cycle and closes the transfer. A later slot-qualified stop without a new `xfer_start` also starts no write cycle.
- R7: An address followed by a stop with no data bytes starts no write cycle, and `next_addr` keeps the loaded address.
- R8: When `busy` falls, `next_addr` equals (address of the last latched byte + 1) modulo 2^ADDR_W.
- R9: While busy, `xfer_start`, `byte_stb` and `stop_pulse` have no effect. `next_addr` stays unchanged and the write stream is unchanged. After busy, bytes arriving without a new `xfer_start` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start | input | 1 | Pulse: write address fully received |
| addr_in | input | ADDR_W | Start address of the write transfer |
| byte_stb | input | 1 | Pulse: a data byte was received and acknowledged |
| byte_in | input | 8 | Received data byte |
| stop_pulse | input | 1 | Pulse: stop condition seen on the bus |
| stop_slot_ok | input | 1 | Stop fell in the slot right after a data-byte acknowledge |
| mem_we | output | 1 | Array write enable, one byte per cycle |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Write cycle in progress |
| next_addr | output | ADDR_W | Address counter value |

## Verification
The assertions assume that `xfer_start`, `byte_stb` and `stop_pulse` are one-cycle pulses and never arrive in the same cycle. They also assume that `stop_slot_ok` matters only when a stop pulse is present. The stimulus drives each pulse alone on a falling edge and clears it on the next falling edge. The sweep covers every start offset of a small page with every byte count from one up to past a full wrap. A bench-side array model starts erased and checks the final contents, the write count, the busy length and the resulting address.

// File: rtl/pgwr_buffer.sv
module pgwr_buffer #(
  parameter int ADDR_W       = 13,
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_start,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_stb,
  input  logic [7:0]        byte_in,
  input  logic              stop_pulse,
  input  logic              stop_slot_ok,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              busy,
  output logic [ADDR_W-1:0] next_addr
);

  localparam int OFF_W    = $clog2(PAGE_BYTES);
  localparam int PG_W     = ADDR_W - OFF_W;
  localparam int BUSY_CYC = (WRITE_CYCLES > PAGE_BYTES) ? WRITE_CYCLES : PAGE_BYTES;
  localparam int TMR_W    = $clog2(BUSY_CYC + 1);

  logic [7:0]            lat_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;
  logic [PG_W-1:0]       page_q;
  logic [OFF_W-1:0]      off_q;
  logic                  armed_q;
  logic                  busy_q;
  logic [TMR_W-1:0]      tmr_q;
  logic [OFF_W:0]        scan_q;
  logic [ADDR_W-1:0]     nxt_q;

  wire [OFF_W-1:0]  scan_off  = scan_q[OFF_W-1:0];
  wire              scan_live = ~scan_q[OFF_W];
  wire              commit    = stop_pulse & stop_slot_ok & armed_q & (|vld_q) & ~busy_q;
  wire [ADDR_W-1:0] last_addr = {page_q, off_q - OFF_W'(1)};

  assign mem_we    = busy_q & scan_live & vld_q[scan_off];
  assign mem_addr  = {page_q, scan_off};
  assign mem_wdata = lat_q[scan_off];
  assign busy      = busy_q;
  assign next_addr = nxt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE_BYTES; i++) lat_q[i] <= 8'hFF;
      vld_q   <= '0;
      page_q  <= '0;
      off_q   <= '0;
      armed_q <= 1'b0;
      busy_q  <= 1'b0;
      tmr_q   <= '0;
      scan_q  <= '0;
      nxt_q   <= '0;
    end else if (busy_q) begin
      if (scan_live) scan_q <= scan_q + 1'b1;
      if (tmr_q == '0) begin
        busy_q <= 1'b0;
        nxt_q  <= last_addr + 1'b1;
      end else begin
        tmr_q <= tmr_q - 1'b1;
      end
    end else begin
      if (xfer_start) begin
        page_q  <= addr_in[ADDR_W-1:OFF_W];
        off_q   <= addr_in[OFF_W-1:0];
        vld_q   <= '0;
        armed_q <= 1'b1;
        nxt_q   <= addr_in;
      end else if (byte_stb && armed_q) begin
        lat_q[off_q] <= byte_in;
        vld_q[off_q] <= 1'b1;
        off_q        <= off_q + 1'b1;
      end
      if (stop_pulse) begin
        armed_q <= 1'b0;
        if (commit) begin
          busy_q <= 1'b1;
          tmr_q  <= TMR_W'(BUSY_CYC - 1);
          scan_q <= '0;
        end
      end
    end
  end

  AST_WE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R5
  AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_pulse && stop_slot_ok)); // R4
  AST_NO_EMPTY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(|vld_q)); // R7
  AST_ADDR_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(next_addr)); // R9
  AST_WRITES_ONE_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W]))); // R5
  AST_WRITES_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr > $past(mem_addr))); // R5

endmodule

// File: tb/sim_pgwr_buffer.sv
module sim_pgwr_buffer;
  localparam int AW = 8;
  localparam int PB = 8;
  localparam int WC = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          xfer_start = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          byte_stb = 1'b0;
  logic [7:0]    byte_in = '0;
  logic          stop_pulse = 1'b0;
  logic          stop_slot_ok = 1'b0;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic          busy;
  logic [AW-1:0] next_addr;

  int n_chk = 0;
  int n_fail = 0;
  int n_wr = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [7:0] arr [256];
  logic [7:0] exp_arr [256];

  pgwr_buffer #(.ADDR_W(AW), .PAGE_BYTES(PB), .WRITE_CYCLES(WC)) u0 (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .addr_in(addr_in),
    .byte_stb(byte_stb), .byte_in(byte_in), .stop_pulse(stop_pulse),
    .stop_slot_ok(stop_slot_ok), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy), .next_addr(next_addr));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_we) begin
      arr[mem_addr] <= mem_wdata;
      n_wr <= n_wr + 1;
    end
  end

  always @(posedge clk) if (cyc > 200000 && !done) begin
    done = 1'b1;
    n_chk++; n_fail++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 200000);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic start_xfer(input logic [AW-1:0] a);
    @(negedge clk); xfer_start = 1'b1; addr_in = a;
    @(negedge clk); xfer_start = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d);
    @(negedge clk); byte_stb = 1'b1; byte_in = d;
    @(negedge clk); byte_stb = 1'b0;
  endtask

  task automatic send_stop(input bit ok);
    @(negedge clk); stop_pulse = 1'b1; stop_slot_ok = ok;
    @(negedge clk); stop_pulse = 1'b0; stop_slot_ok = 1'b0;
  endtask

  task automatic busy_len(output int len);
    len = 0;
    while (busy && len < 200) begin
      len++;
      @(negedge clk);
    end
  endtask

  function automatic int arr_mismatch();
    int m = 0;
    for (int k = 0; k < 256; k++) if (arr[k] !== exp_arr[k]) m++;
    return m;
  endfunction

  initial begin
    int len;
    int w0;
    for (int k = 0; k < 256; k++) begin arr[k] = 8'hFF; exp_arr[k] = 8'hFF; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(mem_we == 1'b0, "R1 mem_we", mem_we, 0);
    chk(next_addr == '0, "R1 next_addr", next_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 address load
    start_xfer(8'h5B);
    chk(next_addr == 8'h5B, "R2 load", next_addr, 8'h5B);
    // R7 address only, then qualified stop
    send_stop(1'b1);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R7 no busy", busy, 0);
    chk(next_addr == 8'h5B, "R7 addr kept", next_addr, 8'h5B);

    // R6 abandoned transfer
    w0 = n_wr;
    start_xfer(8'h20);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
    send_stop(1'b0);
    repeat (WC + 4) @(negedge clk);
    chk(busy == 1'b0, "R6 no busy", busy, 0);
    send_stop(1'b1);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R6 late stop", busy, 0);
    chk(n_wr == w0, "R6 no writes", n_wr - w0, 0);

    // R3 R4 R5 R8 sweep: every start offset, counts 1..PB+4
    for (int s = 0; s < PB; s++) begin
      for (int n = 1; n <= PB + 4; n++) begin
        int pg, a, last, ea, nw;
        pg = (s * 12 + n) % 32;
        a  = pg * PB + s;
        w0 = n_wr;
        start_xfer(AW'(a));
        for (int i = 0; i < n; i++) begin
          logic [7:0] d;
          d = 8'((s * 37 + n * 11 + i * 5 + 1));
          send_byte(d);
          exp_arr[pg * PB + (s + i) % PB] = d;
        end
        send_stop(1'b1);
        busy_len(len);
        chk(len == WC, "R4 busy length", len, WC);
        nw = (n < PB) ? n : PB;
        chk(n_wr - w0 == nw, "R5 write count", n_wr - w0, nw);
        chk(arr_mismatch() == 0, "R3 R5 array contents", arr_mismatch(), 0);
        last = (s + n - 1) % PB;
        ea = (pg * PB + last + 1) % 256;
        chk(next_addr == AW'(ea), "R8 next_addr", next_addr, ea);
      end
    end

    // R9 inputs ignored while busy
    start_xfer(8'h40);
    send_byte(8'hA1); send_byte(8'hA2);
    exp_arr[8'h40] = 8'hA1; exp_arr[8'h41] = 8'hA2;
    send_stop(1'b1);
    chk(busy == 1'b1, "R9 busy up", busy, 1);
    start_xfer(8'h90);
    chk(next_addr == 8'h40, "R9 start ignored", next_addr, 8'h40);
    send_byte(8'h77);
    send_stop(1'b1);
    busy_len(len);
    chk(arr_mismatch() == 0, "R9 array unaffected", arr_mismatch(), 0);
    chk(next_addr == 8'h42, "R9 next_addr", next_addr, 8'h42);
    w0 = n_wr;
    send_byte(8'h55);
    send_stop(1'b1);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R9 unarmed byte", busy, 0);
    chk(n_wr == w0, "R9 no write", n_wr - w0, 0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule